// File: doc/BRIEF.md
# Dual-Mode Expansion Bus Cycle Typer

This block sits on the host side of an expansion bus that runs two kinds of cycle: a 16-bit cycle kept for older cards and a native 32-bit cycle. When the host raises a request, the block captures the whole 32-bit address. In the next clock it matches that address against a fixed set of regions. It then enables only the class of slave that may answer that address.

A native cycle ends when a native slave acknowledges. A legacy cycle ends on its own acknowledge. Either kind ends when a shared timeout counter runs out first, and the block then flags a one-clock timeout error. An address outside every expansion region raises a "not expansion" flag and closes at once, without enabling any slave. Region flags and the cycle-type flag stay valid until the next request is accepted.

Top module: `xbus_cycle_typer`

## Requirements
- R1: After a synchronous reset, every output is low: busy, done, both slave enables, timeout error, cycle-type flag, region flags and the not-expansion flag.
- R2: A request is taken only while idle. The address is captured on the accepting edge, and busy rises on that edge. Later changes of the address bus, and requests made while busy, have no effect on the running cycle.
- R3: One edge after acceptance, exactly one region flag is set for a matching address. The legacy memory flag covers 0x00200000..0x009FFFFF, the legacy expansion flag covers 0x00A00000..0x00B7FFFF, and the legacy I/O flag covers 0x00E80000..0x00EFFFFF. All three lie below 16 MB.
- R4: A legacy-region address raises the legacy slave enable on that same edge. It leaves the native enable and the cycle-type flag low.
- R5: A native-region address (default 0x10000000..0x7FFFFFFF) sets the native region flag, the cycle-type flag and the native slave enable. The two enables are never high together, and the native enable is never high for a legacy-region address.
- R6: An address in no region sets the not-expansion flag, enables no slave, and completes on the decode edge.
- R7: A native cycle ends on the first edge that sees the native acknowledge. The legacy acknowledge has no effect on a native cycle, and the native acknowledge has no effect on a legacy cycle.
- R8: If no matching acknowledge arrives, a cycle ends TMO_CYCLES edges after its enable rose. On that edge a timeout error pulses for exactly one clock, and the enable falls.
- R9: A legacy cycle ends on the first edge that sees the legacy acknowledge.
- R10: Done is high for exactly one clock when a cycle ends, and busy falls on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Start a cycle (taken only while idle) |
| addr | input | 32 | Full cycle address, sampled with req |
| leg_ack | input | 1 | Acknowledge from a legacy slave |
| nat_ack | input | 1 | Acknowledge from a native slave |
| busy | output | 1 | A cycle is in progress |
| done | output | 1 | One-clock end-of-cycle pulse |
| is_native | output | 1 | Current cycle is native 32-bit |
| rgn_leg_mem | output | 1 | Address in legacy memory region |
| rgn_leg_exp | output | 1 | Address in legacy expansion region |
| rgn_leg_io | output | 1 | Address in legacy I/O region |
| rgn_native | output | 1 | Address in native region |
| not_exp | output | 1 | Address matches no expansion region |
| leg_en | output | 1 | Legacy slave enable |
| nat_en | output | 1 | Native slave enable |
| tmo_err | output | 1 | One-clock timeout error pulse |

## Verification
The bench builds the block with TMO_CYCLES set to 8 and the default map. A short limit lets the bench count every edge up to the expiry, for both cycle kinds, and check the enable on the edge before it. With the default map, the region edges can be probed directly: the last byte of legacy memory and the first of legacy expansion, the gap just below native space, and both ends of native space.

// File: rtl/xbus_typer_pkg.sv
package xbus_typer_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_DECODE = 3'd1,
    ST_LEGACY = 3'd2,
    ST_NATIVE = 3'd3,
    ST_DONE   = 3'd4
  } cyc_state_t;

  localparam int NUM_RGN  = 4;
  localparam int RGN_LMEM = 0;
  localparam int RGN_LEXP = 1;
  localparam int RGN_LIO  = 2;
  localparam int RGN_NAT  = 3;

endpackage

// File: rtl/xbus_region_dec.sv
module xbus_region_dec #(
  parameter logic [31:0] LMEM_BASE = 32'h0020_0000,
  parameter logic [31:0] LMEM_LAST = 32'h009F_FFFF,
  parameter logic [31:0] LEXP_BASE = 32'h00A0_0000,
  parameter logic [31:0] LEXP_LAST = 32'h00B7_FFFF,
  parameter logic [31:0] LIO_BASE  = 32'h00E8_0000,
  parameter logic [31:0] LIO_LAST  = 32'h00EF_FFFF,
  parameter logic [31:0] NAT_BASE  = 32'h1000_0000,
  parameter logic [31:0] NAT_LAST  = 32'h7FFF_FFFF
) (
  input  logic [31:0]                        addr,
  output logic [xbus_typer_pkg::NUM_RGN-1:0] hit
);
  import xbus_typer_pkg::*;

  localparam logic [NUM_RGN-1:0][31:0] BASES = {NAT_BASE, LIO_BASE, LEXP_BASE, LMEM_BASE};
  localparam logic [NUM_RGN-1:0][31:0] LASTS = {NAT_LAST, LIO_LAST, LEXP_LAST, LMEM_LAST};

  for (genvar i = 0; i < NUM_RGN; i++) begin : g_rgn
    assign hit[i] = (addr >= BASES[i]) && (addr <= LASTS[i]);
  end

endmodule

// File: rtl/xbus_tmo_ctr.sv
module xbus_tmo_ctr #(
  parameter int LIMIT = 255
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expire
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign expire = run && (cnt == LAST);

endmodule

// File: rtl/xbus_cycle_fsm.sv
module xbus_cycle_fsm (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               req,
  input  logic [xbus_typer_pkg::NUM_RGN-1:0] hit,
  input  logic                               leg_ack,
  input  logic                               nat_ack,
  input  logic                               expire,
  output logic                               accept,
  output logic                               decode,
  output logic                               cnt_run,
  output logic                               busy,
  output logic                               done,
  output logic                               leg_en,
  output logic                               nat_en,
  output logic                               tmo_err
);
  import xbus_typer_pkg::*;

  cyc_state_t state, nxt;
  logic       tmo_nxt;
  logic       leg_hit;

  assign leg_hit = hit[RGN_LMEM] | hit[RGN_LEXP] | hit[RGN_LIO];
  assign accept  = (state == ST_IDLE) && req;
  assign decode  = (state == ST_DECODE);
  assign cnt_run = (state == ST_LEGACY) || (state == ST_NATIVE);

  always_comb begin
    nxt     = state;
    tmo_nxt = 1'b0;
    case (state)
      ST_IDLE:   if (req) nxt = ST_DECODE;
      ST_DECODE: begin
        if (hit[RGN_NAT]) nxt = ST_NATIVE;
        else if (leg_hit) nxt = ST_LEGACY;
        else              nxt = ST_DONE;
      end
      ST_LEGACY: begin
        if (leg_ack) nxt = ST_DONE;
        else if (expire) begin
          nxt     = ST_DONE;
          tmo_nxt = 1'b1;
        end
      end
      ST_NATIVE: begin
        if (nat_ack) nxt = ST_DONE;
        else if (expire) begin
          nxt     = ST_DONE;
          tmo_nxt = 1'b1;
        end
      end
      ST_DONE:   nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      busy    <= 1'b0;
      done    <= 1'b0;
      leg_en  <= 1'b0;
      nat_en  <= 1'b0;
      tmo_err <= 1'b0;
    end else begin
      state   <= nxt;
      busy    <= (nxt != ST_IDLE);
      done    <= (nxt == ST_DONE);
      leg_en  <= (nxt == ST_LEGACY);
      nat_en  <= (nxt == ST_NATIVE);
      tmo_err <= tmo_nxt;
    end
  end

endmodule

// File: rtl/xbus_cycle_typer.sv
module xbus_cycle_typer #(
  parameter int          TMO_CYCLES = 255,
  parameter logic [31:0] NAT_BASE   = 32'h1000_0000,
  parameter logic [31:0] NAT_LAST   = 32'h7FFF_FFFF
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req,
  input  logic [31:0] addr,
  input  logic        leg_ack,
  input  logic        nat_ack,
  output logic        busy,
  output logic        done,
  output logic        is_native,
  output logic        rgn_leg_mem,
  output logic        rgn_leg_exp,
  output logic        rgn_leg_io,
  output logic        rgn_native,
  output logic        not_exp,
  output logic        leg_en,
  output logic        nat_en,
  output logic        tmo_err
);
  import xbus_typer_pkg::*;

  logic [31:0]        addr_q;
  logic [NUM_RGN-1:0] hit;
  logic [NUM_RGN-1:0] rgn_q;
  logic               accept, decode, cnt_run, expire;

  always_ff @(posedge clk) begin
    if (rst) addr_q <= '0;
    else if (accept) addr_q <= addr;
  end

  xbus_region_dec #(
    .NAT_BASE (NAT_BASE),
    .NAT_LAST (NAT_LAST)
  ) u_dec (
    .addr (addr_q),
    .hit  (hit)
  );

  xbus_tmo_ctr #(
    .LIMIT (TMO_CYCLES)
  ) u_tmo (
    .clk    (clk),
    .rst    (rst),
    .run    (cnt_run),
    .expire (expire)
  );

  xbus_cycle_fsm u_fsm (
    .clk     (clk),
    .rst     (rst),
    .req     (req),
    .hit     (hit),
    .leg_ack (leg_ack),
    .nat_ack (nat_ack),
    .expire  (expire),
    .accept  (accept),
    .decode  (decode),
    .cnt_run (cnt_run),
    .busy    (busy),
    .done    (done),
    .leg_en  (leg_en),
    .nat_en  (nat_en),
    .tmo_err (tmo_err)
  );

  always_ff @(posedge clk) begin
    if (rst || accept) begin
      rgn_q     <= '0;
      not_exp   <= 1'b0;
      is_native <= 1'b0;
    end else if (decode) begin
      rgn_q     <= hit;
      not_exp   <= (hit == '0);
      is_native <= hit[RGN_NAT];
    end
  end

  assign rgn_leg_mem = rgn_q[RGN_LMEM];
  assign rgn_leg_exp = rgn_q[RGN_LEXP];
  assign rgn_leg_io  = rgn_q[RGN_LIO];
  assign rgn_native  = rgn_q[RGN_NAT];

endmodule

// File: rtl/xbus_typer_chk.sv
module xbus_typer_chk (
  input logic        clk,
  input logic        rst,
  input logic        busy,
  input logic        done,
  input logic        is_native,
  input logic        rgn_leg_mem,
  input logic        rgn_leg_exp,
  input logic        rgn_leg_io,
  input logic        rgn_native,
  input logic        not_exp,
  input logic        leg_en,
  input logic        nat_en,
  input logic        tmo_err,
  input logic [31:0] addr_q
);

  // R5: the two slave classes are never enabled together
  p_excl_en_r5: assert property (@(posedge clk) disable iff (rst) !(leg_en && nat_en));

  // R5: native enable only with a native decode
  p_nat_only_native_r5: assert property (@(posedge clk) disable iff (rst)
    nat_en |-> (rgn_native && is_native));

  // R3: legacy enable only for an address below 16 MB
  p_leg_low16m_r3: assert property (@(posedge clk) disable iff (rst)
    leg_en |-> (addr_q[31:24] == 8'h00));

  // R3: at most one region flag
  p_onehot_rgn_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rgn_leg_mem, rgn_leg_exp, rgn_leg_io, rgn_native}));

  // R6: unmatched address enables no slave
  p_notexp_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    not_exp |-> (!leg_en && !nat_en));

  // R8: timeout error lasts one clock and coincides with done
  p_tmo_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    tmo_err |-> done ##1 !tmo_err);

  // R10: done is a single pulse followed by idle
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && !busy));

endmodule

bind xbus_cycle_typer xbus_typer_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .busy        (busy),
  .done        (done),
  .is_native   (is_native),
  .rgn_leg_mem (rgn_leg_mem),
  .rgn_leg_exp (rgn_leg_exp),
  .rgn_leg_io  (rgn_leg_io),
  .rgn_native  (rgn_native),
  .not_exp     (not_exp),
  .leg_en      (leg_en),
  .nat_en      (nat_en),
  .tmo_err     (tmo_err),
  .addr_q      (addr_q)
);

// File: tb/xbus_cycle_typer_tb.sv
`timescale 1ns/1ps
module xbus_cycle_typer_tb;

  localparam int TMO = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic [31:0] addr = '0;
  logic        leg_ack = 1'b0;
  logic        nat_ack = 1'b0;
  logic        busy, done, is_native, rgn_leg_mem, rgn_leg_exp, rgn_leg_io, rgn_native;
  logic        not_exp, leg_en, nat_en, tmo_err;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  xbus_cycle_typer #(.TMO_CYCLES(TMO)) u_dut (
    .clk (clk), .rst (rst), .req (req), .addr (addr),
    .leg_ack (leg_ack), .nat_ack (nat_ack),
    .busy (busy), .done (done), .is_native (is_native),
    .rgn_leg_mem (rgn_leg_mem), .rgn_leg_exp (rgn_leg_exp),
    .rgn_leg_io (rgn_leg_io), .rgn_native (rgn_native),
    .not_exp (not_exp), .leg_en (leg_en), .nat_en (nat_en), .tmo_err (tmo_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // packed view: {busy,done,is_native,lmem,lexp,lio,nat,not_exp,leg_en,nat_en,tmo}
  function automatic logic [31:0] outs();
    return {21'd0, busy, done, is_native, rgn_leg_mem, rgn_leg_exp, rgn_leg_io,
            rgn_native, not_exp, leg_en, nat_en, tmo_err};
  endfunction

  // present a request; returns at the negedge after the decode edge
  task automatic start(input logic [31:0] a);
    @(negedge clk);
    addr = a;
    req  = 1'b1;
    @(negedge clk);
    req  = 1'b0;
    addr = 32'hDEAD_BEEF;
    chk("R2 busy after accept", busy, 1);
    @(negedge clk);
  endtask

  task automatic finish_idle(input string tag);
    @(negedge clk);
    chk({tag, " busy low after done"}, {done, busy}, 2'b00);
  endtask

  task automatic t_reset();
    chk("R1 reset outputs", outs(), 0);
  endtask

  task automatic t_legacy(input logic [31:0] a, input logic [2:0] flags);
    start(a);
    chk("R3 legacy region flags", {rgn_leg_mem, rgn_leg_exp, rgn_leg_io, rgn_native}, {flags, 1'b0});
    chk("R4 legacy enable", {leg_en, nat_en, is_native, not_exp}, 4'b1000);
    leg_ack = 1'b1;
    @(negedge clk);
    leg_ack = 1'b0;
    chk("R9 legacy ack ends", {done, leg_en, tmo_err}, 3'b100);
    finish_idle("R10");
  endtask

  task automatic t_native(input logic [31:0] a);
    start(a);
    chk("R5 native flags", {rgn_native, is_native, nat_en, leg_en}, 4'b1110);
    nat_ack = 1'b1;
    @(negedge clk);
    nat_ack = 1'b0;
    chk("R7 native ack ends", {done, nat_en, tmo_err}, 3'b100);
    finish_idle("R10");
  endtask

  task automatic t_unmatched(input logic [31:0] a);
    start(a);
    chk("R6 not expansion", {not_exp, leg_en, nat_en, done,
        rgn_leg_mem, rgn_leg_exp, rgn_leg_io, rgn_native}, 8'b10010000);
    finish_idle("R6");
  endtask

  task automatic t_timeout(input logic [31:0] a, input bit native);
    start(a);
    for (int i = 0; i < TMO - 1; i++) begin
      if (native) nat_ack = 1'b0; else leg_ack = 1'b0;
      // the wrong-class acknowledge must not end the cycle
      if (native) leg_ack = 1'b1; else nat_ack = 1'b1;
      @(negedge clk);
    end
    leg_ack = 1'b0;
    nat_ack = 1'b0;
    chk("R7 wrong ack ignored, enable held", {leg_en | nat_en, done, tmo_err}, 3'b100);
    @(negedge clk);
    chk("R8 timeout pulse", {tmo_err, done, leg_en, nat_en}, 4'b1100);
    @(negedge clk);
    chk("R8 timeout one clock", {tmo_err, busy}, 2'b00);
  endtask

  task automatic t_busy_ignores_req();
    start(32'h2000_0000);
    @(negedge clk);
    req  = 1'b1;
    addr = 32'h0030_0000;
    @(negedge clk);
    req = 1'b0;
    chk("R2 request while busy ignored", {rgn_native, rgn_leg_mem, nat_en, leg_en}, 4'b1010);
    nat_ack = 1'b1;
    @(negedge clk);
    nat_ack = 1'b0;
    @(negedge clk);
    chk("R2 no second cycle", {busy, is_native}, 2'b01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_legacy(32'h0020_0000, 3'b100);
    t_legacy(32'h009F_FFFF, 3'b100);
    t_legacy(32'h00A0_0000, 3'b010);
    t_legacy(32'h00B7_FFFF, 3'b010);
    t_legacy(32'h00E8_1234, 3'b001);
    t_native(32'h1000_0000);
    t_native(32'h7FFF_FFFF);
    t_unmatched(32'h0010_0000);
    t_unmatched(32'h00F8_0000);
    t_unmatched(32'h0FFF_FFFF);
    t_unmatched(32'h8000_0000);
    t_timeout(32'h4000_0000, 1'b1);
    t_timeout(32'h00A4_0000, 1'b0);
    t_busy_ignores_req();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule